// File: doc/BRIEF.md
# 16-QAM Decision-Directed Carrier Phase Detector

This block estimates the carrier phase error of a 16-QAM receiver, one symbol-rate complex sample at a time. Each axis of the sample goes through its own four-level slicer, and the two levels together pick the nearest constellation point. The detector multiplies the sample by the conjugate of that decision. The sign change of the conjugate is built into the multiplier equations, so there is no separate negation stage.

The error is formed in one of two ways, chosen per sample by `mode_i`:

- **Cross mode.** The imaginary part of the conjugate product is the cross-product difference, which is proportional to the sine of the phase error. It is scaled by a gain chosen by the ring (radius) of the decided point. Outer points are far above the noise, so their measurements carry more weight.
- **Angle mode.** Both parts of the product are quantized to six bits. The two six-bit values form a twelve-bit address, which maps to an eight-bit angle.

The three ring gains sit in registers with increasing reset defaults and can be rewritten through a small write port. The result reaches the outputs two cycles after the sample, together with the decided point.

Top module: `qam16_phase_det`

## Requirements
- R1: Inputs are signed with 2^(DW-2) as unit amplitude. Each axis is decided to a signed 3-bit integer on a one-third grid:
  - 3 when 3·v ≥ 2^(DW-1);
  - otherwise 1 when v ≥ 0;
  - otherwise -1 when 3·v ≥ -2^(DW-1);
  - otherwise -3.
- R2: A sample exactly on the zero threshold is decided to the positive inner level 1. An all-zero sample in cross mode gives decisions (1,1) and error 0.
- R3: With `mode_i`=0, the error is (dI·y − dQ·x)·g at full precision, sign-extended to the error width. Here (x,y) is the sample, (dI,dQ) the decision and g the ring gain.
- R4: The ring is classified from the decision and selects the gain:
  - inner, index 0, when both |dI| and |dQ| are 1;
  - middle, index 1, when exactly one of them is 3;
  - outer, index 2, when both are 3.
- R5: After reset the ring gains are 16, 32 and 48 for indices 0, 1 and 2.
- R6: When `gain_we_i` is high at a clock edge, gain index `gain_sel_i` (0 to 2) takes `gain_wdata_i`. A write with `gain_sel_i`=3 has no effect on any gain.
- R7: With `mode_i`=1, the block forms re = dI·x + dQ·y and im = dI·y − dQ·x. Each is shifted arithmetically right by DW-4 and saturated to [-32,31]. The error is an 8-bit signed angle, 256 steps per turn, sign-extended. It lies within 1 step of atan2(im,re), and is 0 when both are 0.
- R8: `valid_o` is high exactly two cycles after `valid_i` was high.
- R9: When no result is due, `err_o`, `dec_i_o` and `dec_q_o` hold their values.
- R10: During and right after reset, `valid_o`, `err_o`, `dec_i_o` and `dec_q_o` are 0.
- R11: The mode is taken per sample, so back-to-back samples may use different modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| mode_i | input | 1 | 0 cross-product error, 1 angle error |
| samp_i_i | input | DW | In-phase sample, signed |
| samp_q_i | input | DW | Quadrature sample, signed |
| gain_we_i | input | 1 | Ring gain write strobe |
| gain_sel_i | input | 2 | Ring gain index |
| gain_wdata_i | input | GW | Ring gain value, unsigned |
| valid_o | output | 1 | Result strobe |
| dec_i_o | output | 3 | Decided in-phase level, signed |
| dec_q_o | output | 3 | Decided quadrature level, signed |
| err_o | output | DW+GW+5 | Phase error, signed |

## Verification
Every result is due two cycles after its sample is captured, so a sample driven on one falling edge is checked on the second falling edge after it. The bench keeps one queue of expected entries, indexed by stimulus cycle. At each falling edge it compares the outputs against the entry from two cycles earlier, including idle entries, where it checks that the strobe is low and that the previous values still hold. A gain write takes effect at the next edge, so gains are changed only while the pipeline is empty, and the results after a write are checked against the new values.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
  typedef enum logic [1:0] {
    RING_INNER = 2'd0,
    RING_MID   = 2'd1,
    RING_OUTER = 2'd2
  } ring_e;

  typedef logic signed [2:0] lvl_t;

  // levels +-3 are 011/101: bits [2:1] differ only for the outer levels
  function automatic ring_e ring_of(lvl_t a, lvl_t b);
    logic oa, ob;
    oa = a[2] ^ a[1];
    ob = b[2] ^ b[1];
    if (oa && ob)      return RING_OUTER;
    else if (oa || ob) return RING_MID;
    return RING_INNER;
  endfunction
endpackage

// File: rtl/qpd_slicer.sv
module qpd_slicer #(
  parameter int DW = 12
) (
  input  logic signed [DW-1:0] x_i,
  output qpd_pkg::lvl_t        lvl_o
);
  localparam int XW = DW + 2;
  // decision threshold 2/3 of unit amplitude, compared against 3*x
  localparam logic signed [XW-1:0] THR = XW'(2**(DW-1));
  localparam qpd_pkg::lvl_t LVL_TAB [4] = '{3'b101, 3'b111, 3'b001, 3'b011};

  logic signed [XW-1:0] x3;
  logic        [1:0]    idx;

  always_comb begin
    x3    = (XW'(x_i) <<< 1) + XW'(x_i);
    idx   = 2'(x3 >= THR) + 2'(x_i >= 0) + 2'(x3 >= -THR);
    lvl_o = LVL_TAB[idx];
  end
endmodule

// File: rtl/qpd_ring_gain.sv
module qpd_ring_gain
  import qpd_pkg::*;
#(
  parameter int GW      = 8,
  parameter int G_INNER = 16,
  parameter int G_MID   = 32,
  parameter int G_OUTER = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [GW-1:0] wdata_i,
  input  ring_e         ring_i,
  output logic [GW-1:0] gain_o
);
  localparam int NR = 3;
  localparam logic [GW-1:0] RST_TAB [NR] = '{GW'(G_INNER), GW'(G_MID), GW'(G_OUTER)};

  logic [GW-1:0] gain_q [NR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NR; g++) gain_q[g] <= RST_TAB[g];
    end else if (we_i) begin
      for (int g = 0; g < NR; g++)
        if (sel_i == 2'(g)) gain_q[g] <= wdata_i;
    end
  end

  always_comb begin
    case (ring_i)
      RING_OUTER: gain_o = gain_q[2];
      RING_MID:   gain_o = gain_q[1];
      default:    gain_o = gain_q[0];
    endcase
  end

  p_gain_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd1) |=> gain_q[1] == $past(wdata_i));

  p_gain_sel3_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd3) |=> $stable(gain_q[0]) && $stable(gain_q[1]) && $stable(gain_q[2]));
endmodule

// File: rtl/qpd_atan.sv
module qpd_atan #(
  parameter int PW = 16,
  parameter int QB = 6,
  parameter int SH = 8,
  parameter int AW = 8
) (
  input  logic signed [PW-1:0] re_i,
  input  logic signed [PW-1:0] im_i,
  output logic signed [AW-1:0] ang_o
);
  localparam int AD = 2 * QB;
  localparam logic signed [PW-1:0] QMAX = PW'(2**(QB-1) - 1);
  localparam logic signed [PW-1:0] QMIN = PW'(-(2**(QB-1)));
  localparam int OCT  = 2**(AW-3);
  // second-order arctangent correction weight, scaled by 2^5
  localparam int K2   = (2**AW * 1390) / 1000;

  function automatic logic signed [QB-1:0] quant(logic signed [PW-1:0] v);
    logic signed [PW-1:0] s;
    s = v >>> SH;
    if (s > QMAX)      s = QMAX;
    else if (s < QMIN) s = QMIN;
    return QB'(s);
  endfunction

  // angle within one octant from ratio r8 = min/max in Q8
  function automatic int oct_ang(int r8);
    return ((r8 << (AW + 10)) + r8 * (256 - r8) * K2 + (1 << 20)) >>> 21;
  endfunction

  // angle of the point addressed by {re, im}; behaves as a 2^AD-entry table
  function automatic logic [AW-1:0] ang_tab(logic [AD-1:0] a);
    int re, im, ax, ay, base, full;
    re = int'(signed'(a[AD-1:QB]));
    im = int'(signed'(a[QB-1:0]));
    ax = (re < 0) ? -re : re;
    ay = (im < 0) ? -im : im;
    if (ax == 0 && ay == 0) return '0;
    if (ay <= ax) base = oct_ang((ay * 256) / ax);
    else          base = 2 * OCT - oct_ang((ax * 256) / ay);
    if (re >= 0 && im >= 0) full = base;
    else if (re < 0 && im >= 0) full = 4 * OCT - base;
    else if (re < 0)            full = 4 * OCT + base;
    else                        full = 8 * OCT - base;
    return AW'(full);
  endfunction

  logic [AD-1:0] addr;

  always_comb begin
    addr  = {quant(re_i), quant(im_i)};
    ang_o = signed'(ang_tab(addr));
  end
endmodule

// File: rtl/qam16_phase_det.sv
module qam16_phase_det
  import qpd_pkg::*;
#(
  parameter int DW      = 12,
  parameter int GW      = 8,
  parameter int QB      = 6,
  parameter int AW      = 8,
  parameter int G_INNER = 16,
  parameter int G_MID   = 32,
  parameter int G_OUTER = 48
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     mode_i,
  input  logic signed [DW-1:0]     samp_i_i,
  input  logic signed [DW-1:0]     samp_q_i,
  input  logic                     gain_we_i,
  input  logic [1:0]               gain_sel_i,
  input  logic [GW-1:0]            gain_wdata_i,
  output logic                     valid_o,
  output logic signed [2:0]        dec_i_o,
  output logic signed [2:0]        dec_q_o,
  output logic signed [DW+GW+4:0]  err_o
);
  localparam int PW = DW + 4;
  localparam int EW = DW + GW + 5;
  localparam int SH = DW - 4;

  // stage 1: slice and capture
  logic signed [DW-1:0] samp_w [2];
  lvl_t                 dec_w  [2];

  assign samp_w[0] = samp_i_i;
  assign samp_w[1] = samp_q_i;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    qpd_slicer #(.DW(DW)) u_slicer (
      .x_i   (samp_w[a]),
      .lvl_o (dec_w[a])
    );
  end

  logic                 s1_v, s1_mode;
  logic signed [DW-1:0] s1_x, s1_y;
  lvl_t                 s1_di, s1_dq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v    <= 1'b0;
      s1_mode <= 1'b0;
      s1_x    <= '0;
      s1_y    <= '0;
      s1_di   <= '0;
      s1_dq   <= '0;
    end else begin
      s1_v <= valid_i;
      if (valid_i) begin
        s1_mode <= mode_i;
        s1_x    <= samp_i_i;
        s1_y    <= samp_q_i;
        s1_di   <= dec_w[0];
        s1_dq   <= dec_w[1];
      end
    end
  end

  // stage 2: sample times conjugate decision, sign of conjugate folded in
  logic signed [PW-1:0] x_e, y_e, di_e, dq_e, re_w, im_w;
  logic signed [AW-1:0] ang_w;
  logic signed [EW-1:0] cross_w;
  logic [GW-1:0]        gain_w;
  ring_e                ring_w;

  always_comb begin
    x_e    = PW'(s1_x);
    y_e    = PW'(s1_y);
    di_e   = PW'(s1_di);
    dq_e   = PW'(s1_dq);
    re_w   = x_e * di_e + y_e * dq_e;
    im_w   = y_e * di_e - x_e * dq_e;
    ring_w = ring_of(s1_di, s1_dq);
  end

  qpd_ring_gain #(
    .GW(GW), .G_INNER(G_INNER), .G_MID(G_MID), .G_OUTER(G_OUTER)
  ) u_gain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (gain_we_i),
    .sel_i   (gain_sel_i),
    .wdata_i (gain_wdata_i),
    .ring_i  (ring_w),
    .gain_o  (gain_w)
  );

  qpd_atan #(.PW(PW), .QB(QB), .SH(SH), .AW(AW)) u_atan (
    .re_i  (re_w),
    .im_i  (im_w),
    .ang_o (ang_w)
  );

  assign cross_w = EW'(im_w) * EW'($signed({1'b0, gain_w}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dec_i_o <= '0;
      dec_q_o <= '0;
      err_o   <= '0;
    end else begin
      valid_o <= s1_v;
      if (s1_v) begin
        dec_i_o <= s1_di;
        dec_q_o <= s1_dq;
        err_o   <= s1_mode ? EW'(ang_w) : cross_w;
      end
    end
  end

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i, 2));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i, 2) |-> $stable(err_o) && $stable(dec_i_o) && $stable(dec_q_o));

  p_dec_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> dec_i_o[0] && dec_q_o[0]);

  p_tie_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i, 2) && !$past(mode_i, 2) && $past(samp_i_i, 2) == 0 && $past(samp_q_i, 2) == 0)
      |-> dec_i_o == 3'sd1 && dec_q_o == 3'sd1 && err_o == 0);
endmodule

// File: tb/qam16_phase_det_bench.sv
`timescale 1ns/1ps
module qam16_phase_det_bench;
  localparam int DW = 12, GW = 8, EW = DW + GW + 5, N = 512;
  localparam int UNIT = 2**(DW-2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, mode = 1'b0, gwe = 1'b0;
  logic [1:0] gsel = '0;
  logic [GW-1:0] gdata = '0;
  logic signed [DW-1:0] sx = '0, sy = '0;
  logic valid_o;
  logic signed [2:0] dec_i_o, dec_q_o;
  logic signed [EW-1:0] err_o;

  qam16_phase_det u_qam16_phase_det (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode),
    .samp_i_i(sx), .samp_q_i(sy), .gain_we_i(gwe), .gain_sel_i(gsel),
    .gain_wdata_i(gdata), .valid_o(valid_o), .dec_i_o(dec_i_o),
    .dec_q_o(dec_q_o), .err_o(err_o)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_st = 0;
  int gains [3];
  int st_x [N], st_y [N], e_di [N], e_dq [N];
  bit st_v [N], st_m [N];
  longint e_err [N];
  string st_tag [N];
  logic signed [EW-1:0] last_err;

  function automatic int slice_ref(int v);
    if (3 * v >= 2**(DW-1)) return 3;
    if (v >= 0) return 1;
    if (3 * v >= -(2**(DW-1))) return -1;
    return -3;
  endfunction

  function automatic int quant_ref(int v);
    int s = v >>> (DW - 4);
    if (s > 31) return 31;
    if (s < -32) return -32;
    return s;
  endfunction

  function automatic int ang_ref(int re, int im);
    real a;
    if (re == 0 && im == 0) return 0;
    a = $atan2(real'(im), real'(re)) * 256.0 / (2.0 * 3.14159265358979);
    return $rtoi($floor(a + 0.5));
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add(int x, int y, bit v, bit m, string tag);
    int di, dq, ring;
    di = slice_ref(x);
    dq = slice_ref(y);
    ring = ((di == 3 || di == -3) ? 1 : 0) + ((dq == 3 || dq == -3) ? 1 : 0);
    st_x[n_st] = x; st_y[n_st] = y; st_v[n_st] = v; st_m[n_st] = m;
    st_tag[n_st] = tag; e_di[n_st] = di; e_dq[n_st] = dq;
    if (m) e_err[n_st] = ang_ref(quant_ref(di * x + dq * y), quant_ref(di * y - dq * x));
    else   e_err[n_st] = longint'(di * y - dq * x) * gains[ring];
    n_st++;
  endtask

  task automatic check_out(int k);
    if (st_v[k]) begin
      check(valid_o == 1'b1, "R8", "valid_o two cycles after sample", valid_o, 1);
      check(dec_i_o == e_di[k], "R1", "decided I level", dec_i_o, e_di[k]);
      check(dec_q_o == e_dq[k], "R1", "decided Q level", dec_q_o, e_dq[k]);
      if (st_m[k]) begin
        int d = int'(err_o) - int'(e_err[k]);
        d = ((d % 256) + 256 + 128) % 256 - 128;
        check(d >= -1 && d <= 1, st_tag[k], "angle error", err_o, e_err[k]);
      end else begin
        check(longint'(err_o) == e_err[k], st_tag[k], "cross error", err_o, e_err[k]);
      end
    end else begin
      check(valid_o == 1'b0, "R8", "valid_o idle", valid_o, 0);
      check(err_o == last_err, "R9", "err_o held while idle", err_o, last_err);
    end
  endtask

  task automatic play();
    for (int c = 0; c < n_st + 2; c++) begin
      @(negedge clk);
      if (c >= 2) check_out(c - 2);
      last_err = err_o;
      if (c < n_st) begin
        valid = st_v[c]; mode = st_m[c];
        sx = DW'(st_x[c]); sy = DW'(st_y[c]);
      end else begin
        valid = 1'b0;
      end
    end
    n_st = 0;
  endtask

  task automatic gain_write(int sel, int val);
    @(negedge clk);
    gwe = 1'b1; gsel = 2'(sel); gdata = GW'(val);
    @(negedge clk);
    gwe = 1'b0;
  endtask

  function automatic int rnd_axis();
    int lv;
    if ($urandom_range(0, 1) == 0) return int'($urandom_range(0, 4095)) - 2048;
    lv = 2 * int'($urandom_range(0, 3)) - 3;
    return lv * UNIT / 3 + int'($urandom_range(0, 400)) - 200;
  endfunction

  task automatic add_random(int count, string cross_tag);
    for (int i = 0; i < count; i++) begin
      bit m = bit'($urandom_range(0, 1));
      add(rnd_axis(), rnd_axis(), $urandom_range(0, 3) != 0, m, m ? "R7" : cross_tag);
    end
  endtask

  task automatic add_rings(string tag);
    add(341, 50, 1'b1, 1'b0, tag);      // inner ring
    add(-1000, 60, 1'b1, 1'b0, tag);    // middle ring
    add(-1030, 1010, 1'b1, 1'b0, tag);  // outer ring
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1f3a_5c07));
    gains[0] = 16; gains[1] = 32; gains[2] = 48;
    repeat (3) @(negedge clk);
    check(valid_o == 0 && err_o == 0, "R10", "outputs in reset", err_o, 0);
    check(dec_i_o == 0 && dec_q_o == 0, "R10", "decisions in reset", dec_i_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o == 0 && err_o == 0, "R10", "outputs after reset", err_o, 0);

    // default gains, thresholds, tie, modes
    add(0, 0, 1'b1, 1'b0, "R2");
    add(683, -683, 1'b1, 1'b0, "R1");
    add(682, -682, 1'b1, 1'b0, "R1");
    add_rings("R5");
    add(0, 0, 1'b1, 1'b1, "R7");
    add(2047, -2048, 1'b1, 1'b1, "R7");
    add(700, -300, 1'b1, 1'b1, "R11");  // same sample, angle then cross
    add(700, -300, 1'b1, 1'b0, "R11");
    add(0, 0, 1'b0, 1'b0, "R9");
    add_random(300, "R3");
    play();

    // ignored write index, then rewritten gains
    gain_write(3, 99);
    add_rings("R6");
    play();
    gain_write(0, 5);
    gain_write(1, 77);
    gain_write(2, 200);
    gains[0] = 5; gains[1] = 77; gains[2] = 200;
    add_rings("R4");
    add_random(120, "R6");
    play();
    finish_run();
  end
endmodule